// File: doc/BRIEF.md
# Montgomery Negative-Inverse Byte Calculator

This block derives the low byte of the Montgomery constant N' from the low byte of an odd modulus N. The result is chosen so that N multiplied by N' leaves all ones in the low byte, which means the product is congruent to -1 modulo 256. A wide modular multiplier elsewhere on the chip uses this constant in its reduction step.

A host write of the modulus byte starts the work on its own. The block then resolves one result bit per clock cycle. In each cycle it looks at the current bit of a running product. When that bit is zero, it sets the matching bit of N' and adds N, shifted to that bit position, into the product. A busy flag covers the whole window. The result lands in a register word that also holds a 5-bit side field. The host may load that word directly, so a constant computed elsewhere can be supplied without running the sequence.

When the sequence finishes, a one-cycle done pulse tells downstream command logic that it may launch an operation that depends on N'. A new modulus write during a run discards the run in progress and starts again from the new byte.

Top module: `nprime_calc`

## Requirements
- R1: After a run on an odd byte N, the result field holds N' such that (N * N') mod 256 = 255.
- R2: A modulus write (`mod_wr` high at a rising edge) sets `busy` from the next cycle onward. `busy` is also visible as bit 8 of `result_word`.
- R3: `busy` stays high for exactly 8 cycles after an uninterrupted start. The new result is present in `result_word[7:0]` in the first cycle in which `busy` reads low, and it changes at no other time except through a host write.
- R4: For an odd input byte, bit 0 of the computed result is 1.
- R5: A host write (`word_wr` high) loads `word_res` into `result_word[7:0]` and `word_aux` into `result_word[20:16]`. Both are readable in the next cycle.
- R6: A run never changes the side field `result_word[20:16]`. Only a host write may change it.
- R7: A modulus write while `busy` is high restarts the run from the new byte. The interrupted run produces no result and no done pulse, and `busy` stays high for 8 more cycles after the restarting write.
- R8: `done` is high for exactly one cycle, the first cycle in which `busy` reads low after a completed run.
- R9: After reset, `result_word` is all zero and `busy` and `done` are low.
- R10: If the host writes the word during a run, the side field keeps the host value. The result field is overwritten by the computed N' when the run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_wr | input | 1 | Strobe: write the modulus low byte and start a run |
| mod_byte | input | 8 | Modulus low byte, must be odd |
| word_wr | input | 1 | Strobe: direct host load of the result word |
| word_res | input | 8 | Result value for a direct host load |
| word_aux | input | 5 | Side field value for a direct host load |
| result_word | output | 32 | Readback word: result [7:0], busy [8], side field [20:16], other bits 0 |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when a run has completed |

## Verification
The bench builds the block with its default parameters: an 8-bit result, a 5-bit side field at bit 16, and a 32-bit readback word. With these values the whole legal input space, all 128 odd bytes, can be swept run after run, and each result is compared against a brute-force search for the inverse. The same setting keeps the restart and mid-run host-write cases short. In those cases the exact busy length of 8 cycles and the cycle-accurate placement of the done pulse can be counted directly.

// File: rtl/nprime_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and the sequencer state type for the N' calculator.
// Assumes: widths here are defaults only; modules take their own parameters.
package nprime_pkg;

    localparam int unsigned DEF_RES_W  = 8;   // result width (bits of N')
    localparam int unsigned DEF_AUX_W  = 5;   // side field width
    localparam int unsigned DEF_AUX_LSB = 16; // side field position in readback word
    localparam int unsigned DEF_WORD_W = 32;  // readback word width

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/nprime_seq.sv
`timescale 1ns/1ps
// Module: nprime_seq
// Sequences one run: a start begins a run of RES_W steps, one per cycle.
// A start during a run restarts it. The finishing cycle raises fin, and
// done follows one cycle later, exactly once per completed run.
// Assumes: start is a single-cycle strobe from the host write path.
module nprime_seq
    import nprime_pkg::*;
#(
    parameter int unsigned RES_W = DEF_RES_W,
    localparam int unsigned CW = $clog2(RES_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          step,
    output logic [CW-1:0] bit_idx,
    output logic          fin,
    output logic          busy,
    output logic          done
);

    localparam logic [CW-1:0] LAST_IDX = CW'(RES_W - 1);

    seq_state_t    state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          last;

    // Decode the final step, and suppress finishing when a restart arrives.
    always_comb begin
        last = (state_q == SEQ_RUN) && (cnt_q == LAST_IDX);
        fin  = last && !start;
    end

    // State, bit counter and the delayed completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= fin;
            if (start) begin
                state_q <= SEQ_RUN;
                cnt_q   <= '0;
            end else if (state_q == SEQ_RUN) begin
                if (last) begin
                    state_q <= SEQ_IDLE;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign step    = (state_q == SEQ_RUN);
    assign bit_idx = cnt_q;
    assign busy    = (state_q == SEQ_RUN);
    assign done    = done_q;

endmodule

// File: rtl/nprime_datapath.sv
`timescale 1ns/1ps
// Module: nprime_datapath
// Bit-serial solver for N' with N*N' = -1 mod 2^RES_W. Step i inspects bit i
// of the running product. If it is clear, bit i of N' is set and N<<i is
// added. np_next presents the value after the current step, so the result
// can be captured on the finishing edge.
// Assumes: the loaded byte is odd; an even byte gives no valid inverse.
module nprime_datapath
    import nprime_pkg::*;
#(
    parameter int unsigned RES_W = DEF_RES_W,
    localparam int unsigned CW = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] n_in,
    input  logic             step,
    input  logic [CW-1:0]    bit_idx,
    output logic [RES_W-1:0] np_next
);

    logic [RES_W-1:0] n_q;
    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] np_q;
    logic [RES_W-1:0] set_vec;
    logic [RES_W-1:0] shifted_n;
    logic [RES_W-1:0] acc_next;

    // One set-decision per result bit: active on its own step with a clear product bit.
    for (genvar i = 0; i < RES_W; i++) begin : g_bit
        assign set_vec[i] = step && (bit_idx == CW'(i)) && !acc_q[i];
    end

    // Next product and next partial inverse for the current step.
    always_comb begin
        shifted_n = n_q << bit_idx;
        acc_next  = (|set_vec) ? (acc_q + shifted_n) : acc_q;
        np_next   = np_q | set_vec;
    end

    // Operand capture on start, then per-step update of product and inverse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q   <= '0;
            acc_q <= '0;
            np_q  <= '0;
        end else if (load) begin
            n_q   <= n_in;
            acc_q <= '0;
            np_q  <= '0;
        end else if (step) begin
            acc_q <= acc_next;
            np_q  <= np_next;
        end
    end

endmodule

// File: rtl/nprime_resreg.sv
`timescale 1ns/1ps
// Module: nprime_resreg
// Holds the result field and the side field. A host write loads both. A
// finishing run loads the result field only and wins over a host write in
// the same cycle.
// Assumes: fin is high for one cycle per completed run.
module nprime_resreg
    import nprime_pkg::*;
#(
    parameter int unsigned RES_W = DEF_RES_W,
    parameter int unsigned AUX_W = DEF_AUX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [RES_W-1:0] host_res,
    input  logic [AUX_W-1:0] host_aux,
    input  logic             fin,
    input  logic [RES_W-1:0] calc_res,
    output logic [RES_W-1:0] res,
    output logic [AUX_W-1:0] aux
);

    logic [RES_W-1:0] res_q;
    logic [AUX_W-1:0] aux_q;

    // Result field: the computed value has priority over the host value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (fin) begin
            res_q <= calc_res;
        end else if (host_wr) begin
            res_q <= host_res;
        end
    end

    // Side field: only the host writes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_q <= '0;
        end else if (host_wr) begin
            aux_q <= host_aux;
        end
    end

    assign res = res_q;
    assign aux = aux_q;

endmodule

// File: rtl/nprime_calc.sv
`timescale 1ns/1ps
// Module: nprime_calc (top)
// Montgomery negative-inverse byte calculator. A modulus-byte write starts a
// RES_W-cycle bit-serial run. The readback word shows the result at the low
// bits, busy just above it, and a host-owned side field at AUX_LSB.
// Assumes: AUX_LSB > RES_W and AUX_LSB + AUX_W <= WORD_W.
module nprime_calc
    import nprime_pkg::*;
#(
    parameter int unsigned RES_W   = DEF_RES_W,
    parameter int unsigned AUX_W   = DEF_AUX_W,
    parameter int unsigned AUX_LSB = DEF_AUX_LSB,
    parameter int unsigned WORD_W  = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_wr,
    input  logic [RES_W-1:0]  mod_byte,
    input  logic              word_wr,
    input  logic [RES_W-1:0]  word_res,
    input  logic [AUX_W-1:0]  word_aux,
    output logic [WORD_W-1:0] result_word,
    output logic              busy,
    output logic              done
);

    localparam int unsigned CW       = $clog2(RES_W);
    localparam int unsigned BUSY_POS = RES_W;

    logic          step;
    logic [CW-1:0] bit_idx;
    logic          fin;
    logic          busy_w;
    logic          done_w;
    logic [RES_W-1:0] np_next;
    logic [RES_W-1:0] res;
    logic [AUX_W-1:0] aux;

    nprime_seq #(.RES_W(RES_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (mod_wr),
        .step    (step),
        .bit_idx (bit_idx),
        .fin     (fin),
        .busy    (busy_w),
        .done    (done_w)
    );

    nprime_datapath #(.RES_W(RES_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (mod_wr),
        .n_in    (mod_byte),
        .step    (step),
        .bit_idx (bit_idx),
        .np_next (np_next)
    );

    nprime_resreg #(.RES_W(RES_W), .AUX_W(AUX_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wr  (word_wr),
        .host_res (word_res),
        .host_aux (word_aux),
        .fin      (fin),
        .calc_res (np_next),
        .res      (res),
        .aux      (aux)
    );

    // Assemble the readback word from the fields and the live busy flag.
    always_comb begin
        result_word                     = '0;
        result_word[RES_W-1:0]          = res;
        result_word[BUSY_POS]           = busy_w;
        result_word[AUX_LSB +: AUX_W]   = aux;
    end

    assign busy = busy_w;
    assign done = done_w;

endmodule

// File: rtl/nprime_calc_chk.sv
`timescale 1ns/1ps
// Module: nprime_calc_chk
// Protocol and result properties for nprime_calc, attached by bind.
// Assumes: synchronous active-low reset held from time zero.
module nprime_calc_chk #(
    parameter int unsigned RES_W   = 8,
    parameter int unsigned AUX_W   = 5,
    parameter int unsigned AUX_LSB = 16,
    parameter int unsigned WORD_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mod_wr,
    input logic [RES_W-1:0]  mod_byte,
    input logic              word_wr,
    input logic [AUX_W-1:0]  word_aux,
    input logic [WORD_W-1:0] result_word,
    input logic              busy,
    input logic              done
);

    logic [RES_W-1:0]   last_n;
    logic               have_n;
    logic [2*RES_W-1:0] prod;

    // Remember the most recent modulus byte for the inverse check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_n <= '0;
            have_n <= 1'b0;
        end else if (mod_wr) begin
            last_n <= mod_byte;
            have_n <= 1'b1;
        end
    end

    assign prod = (2*RES_W)'(last_n) * (2*RES_W)'(result_word[RES_W-1:0]);

    p_inverse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && have_n && last_n[0]) |-> (prod[RES_W-1:0] == {RES_W{1'b1}}));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mod_wr |=> busy);

    p_busy_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        result_word[RES_W] == busy);

    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    p_result_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !word_wr |=> ($stable(result_word[RES_W-1:0]) || done));

    p_aux_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_wr |=> (result_word[AUX_LSB +: AUX_W] == $past(word_aux)));

    p_aux_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !word_wr |=> $stable(result_word[AUX_LSB +: AUX_W]));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind nprime_calc nprime_calc_chk #(
    .RES_W(RES_W), .AUX_W(AUX_W), .AUX_LSB(AUX_LSB), .WORD_W(WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mod_wr      (mod_wr),
    .mod_byte    (mod_byte),
    .word_wr     (word_wr),
    .word_aux    (word_aux),
    .result_word (result_word),
    .busy        (busy),
    .done        (done)
);

// File: tb/nprime_calc_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected runs, a monitor checks each done.
module nprime_calc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_wr = 1'b0;
    logic [7:0]  mod_byte = '0;
    logic        word_wr = 1'b0;
    logic [7:0]  word_res = '0;
    logic [4:0]  word_aux = '0;
    logic [31:0] result_word;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] res;
        logic [4:0] aux;
        int         runlen;
    } exp_t;

    exp_t exp_q[$];
    logic [4:0] exp_aux = '0;
    int busy_run = 0;
    bit prev_done = 1'b0;

    always #2.5 clk = ~clk;

    nprime_calc uut (
        .clk(clk), .rst_n(rst_n), .mod_wr(mod_wr), .mod_byte(mod_byte),
        .word_wr(word_wr), .word_res(word_res), .word_aux(word_aux),
        .result_word(result_word), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    // Brute-force reference: search for the odd x with n*x = 255 mod 256.
    function automatic logic [7:0] ref_inv(input logic [7:0] n);
        for (int x = 1; x < 256; x += 2) begin
            if (((int'(n) * x) & 255) == 255) return x[7:0];
        end
        return 8'h00;
    endfunction

    // Start a run at the current negedge; optionally queue its expected outcome.
    task automatic kick(input logic [7:0] n, input bit push, input int runlen);
        exp_t e;
        mod_wr   = 1'b1;
        mod_byte = n;
        if (push) begin
            e.res = ref_inv(n);
            e.aux = exp_aux;
            e.runlen = runlen;
            exp_q.push_back(e);
        end
        @(negedge clk);
        mod_wr = 1'b0;
    endtask

    // Direct host load of the word at the current negedge.
    task automatic host_write(input logic [7:0] r, input logic [4:0] a);
        word_wr  = 1'b1;
        word_res = r;
        word_aux = a;
        exp_aux  = a;
        @(negedge clk);
        word_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: track busy length, pop and compare on each done.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (prev_done) chk(!done, "R8 done single cycle", {31'b0, done}, 32'd0);
            if (busy) busy_run++;
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(result_word[7:0] == e.res, "R1 result", {24'b0, result_word[7:0]}, {24'b0, e.res});
                    chk(result_word[0], "R4 odd result", {31'b0, result_word[0]}, 32'd1);
                    chk(result_word[20:16] == e.aux, "R6 side field kept", {27'b0, result_word[20:16]}, {27'b0, e.aux});
                    chk(!busy && !result_word[8], "R3 busy low at result", {31'b0, busy}, 32'd0);
                    chk(busy_run == e.runlen, "R3 busy length", busy_run, e.runlen);
                end
                busy_run = 0;
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(result_word == 32'd0, "R9 reset word", result_word, 32'd0);
        chk(!busy && !done, "R9 reset flags", {30'b0, busy, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: busy visible the cycle after the start write
        kick(8'h01, 1'b1, 8);
        chk(busy && result_word[8], "R2 busy after start", {31'b0, busy}, 32'd1);
        wait_idle();

        // R1 R3 R4: full sweep of odd bytes
        for (int n = 1; n < 256; n += 2) begin
            kick(n[7:0], 1'b1, 8);
            wait_idle();
        end

        // R5: direct host load while idle
        host_write(8'h3C, 5'h15);
        chk(result_word == 32'h0015_003C, "R5 host load", result_word, 32'h0015_003C);

        // R6: a run keeps the host side field
        kick(8'hA7, 1'b1, 8);
        wait_idle();

        // R7: restart during a run, first run gives nothing
        kick(8'h35, 1'b0, 0);
        repeat (2) @(negedge clk);
        kick(8'hCB, 1'b1, 11);
        wait_idle();

        // R10: host load during a run; side field kept, result overwritten at end
        kick(8'h5F, 1'b1, 8);
        @(negedge clk);
        host_write(8'h00, 5'h0A);
        exp_q[0].aux = 5'h0A;
        chk(result_word == 32'h000A_0100, "R10 host load mid-run", result_word, 32'h000A_0100);
        wait_idle();
        chk(result_word == {11'b0, 5'h0A, 8'b0, ref_inv(8'h5F)}, "R10 final word",
            result_word, {11'b0, 5'h0A, 8'b0, ref_inv(8'h5F)});

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule